// File: doc/BRIEF.md
# External Bus Transfer Acknowledge Controller

This block is a master for an external memory bus with a single chip select. A request from the internal side carries an address, a transfer size, a direction and, for writes, up to a 16-byte line of data. The block turns that request into one or more bus beats. It drives chip select, a burst flag, the size code, the beat address and the write data. It then ends each beat on an acknowledge.

The acknowledge can come from two places. The block can count a configured number of wait states and acknowledge the beat itself. The attached peripheral can also pull an active-low acknowledge input, and this can end a beat before the countdown runs out. When internal acknowledge is switched off, only the peripheral can end a beat. In that mode a timeout counter aborts a beat that is never acknowledged and reports an error, so the bus cannot hang.

The port width is 8, 16 or 32 bits. A transfer wider than the port becomes a burst with one beat per port-width slice. Burst addresses wrap inside a block the size of the transfer. Each request gets one response: the read data assembled in beat order, plus an error flag.

Top module: `ebus_ack_ctrl`

## Requirements
- R1: During and right after reset, cs_n_o and burst_n_o are high, req_ready_o is high, and rsp_valid_o and wdata_oe_o are low.
- R2: A request is accepted in a cycle where req_valid_i and req_ready_o are both high. cs_n_o goes low in the next cycle. req_ready_o stays low from then until the response cycle is over.
- R3: With internal acknowledge on (cfg_auto_ack_i=1) and no external acknowledge, each beat lasts cfg_wait_i+1 cycles.
- R4: ta_ni low in a beat cycle ends that beat in that cycle, even if wait states remain. With internal acknowledge off, only ta_ni ends a beat.
- R5: ta_ni is ignored while cs_n_o is high. It starts no transfer, produces no response and does not shorten the next beat.
- R6: On a read, the low port-width bytes of rdata_i are captured in the acknowledge cycle of each beat. Beat k fills bytes k*pb to k*pb+pb-1 of rsp_rdata_o, where pb is the port width in bytes. Bytes that were not read are zero.
- R7: cs_n_o goes high in the cycle after the final acknowledge. rsp_valid_o is high for exactly that one cycle.
- R8: On a write, wdata_oe_o stays high in the cycle after cs_n_o rises. It is low from the following cycle.
- R9: The beat count is size/pb when size > pb, and 1 otherwise. burst_n_o is low during every beat of a transfer with more than one beat. On a write, beat k drives bytes k*pb onwards of req_wdata_i on the low pb lanes of wdata_o, and drives zero on the other lanes.
- R10: Size code on req_size_i and tsize_o: 2'b01 = 1 byte, 2'b10 = 2 bytes, 2'b00 = 4 bytes, 2'b11 = 16 bytes. Port code on cfg_port_i: 2'b01 = 8-bit, 2'b10 = 16-bit, any other value = 32-bit. tsize_o shows the request's size code during the beats.
- R11: The address of beat k is (A & ~(S-1)) | ((A + k*pb) & (S-1)), where A is the start address and S is the size in bytes. The address therefore wraps within the size-aligned block.
- R12: With internal acknowledge off, a beat that gets no acknowledge for TMO_CYCLES cycles is aborted in its TMO_CYCLES-th cycle. Any remaining beats are dropped, and rsp_err_o is high in the response cycle.
- R13: The wait-state count reloads at the start of every beat, so each beat of a burst waits the full cfg_wait_i cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Start address |
| req_size_i | input | 2 | Transfer size code |
| req_wdata_i | input | 8*LINE_BYTES | Write data in beat order |
| cfg_port_i | input | 2 | Port width code |
| cfg_auto_ack_i | input | 1 | Enable internal acknowledge |
| cfg_wait_i | input | WAIT_W | Wait states per beat |
| rsp_valid_o | output | 1 | Response cycle |
| rsp_err_o | output | 1 | Transfer aborted by timeout |
| rsp_rdata_o | output | 8*LINE_BYTES | Assembled read data |
| cs_n_o | output | 1 | Chip select, active low |
| burst_n_o | output | 1 | Burst in progress, active low |
| tsize_o | output | 2 | Size code of current transfer |
| addr_o | output | ADDR_W | Beat address |
| we_o | output | 1 | Write direction of current transfer |
| wdata_o | output | 8*BUS_BYTES | Beat write data |
| wdata_oe_o | output | 1 | Write data drive enable |
| rdata_i | input | 8*BUS_BYTES | Read data from peripheral |
| ta_ni | input | 1 | External transfer acknowledge, active low |

## Verification
The bench targets beats where the external acknowledge arrives before the wait countdown ends. A design that ignored the early acknowledge would stretch those beats to the full wait length. Misaligned 16-byte and 4-byte bursts on narrow ports check address wrap; a design without wrap would run past the block boundary. The bench also checks the single tail cycle, where chip select is released but write data is still driven. Getting that cycle wrong shows up as data dropped with chip select, or as chip select held one cycle too long. Finally, the bench holds the acknowledge low while idle and lets a manual-mode beat run without any acknowledge. The first case catches a controller that honours a stray acknowledge. The second catches one that hangs instead of flagging an error.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_TAIL = 2'd2
  } ebus_state_e;

  localparam logic [1:0] SZ_4B  = 2'b00;
  localparam logic [1:0] SZ_1B  = 2'b01;
  localparam logic [1:0] SZ_2B  = 2'b10;
  localparam logic [1:0] SZ_16B = 2'b11;

  localparam logic [1:0] PW_32 = 2'b00;
  localparam logic [1:0] PW_8  = 2'b01;
  localparam logic [1:0] PW_16 = 2'b10;

  function automatic logic [2:0] size_log2(input logic [1:0] sz);
    case (sz)
      SZ_1B:   return 3'd0;
      SZ_2B:   return 3'd1;
      SZ_16B:  return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [1:0] port_log2(input logic [1:0] pw);
    case (pw)
      PW_8:    return 2'd0;
      PW_16:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/ebus_beat_seq.sv
module ebus_beat_seq
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic              active_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        port_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [1:0]        plog_o,
  output logic              last_o,
  output logic              burst_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [2:0]        slog_q;
  logic [1:0]        plog_q;
  logic [IDX_W-1:0]  bm1_q;
  logic [IDX_W-1:0]  idx_q;

  logic [2:0]        sl_new;
  logic [2:0]        pl_new;
  logic [2:0]        blog;
  logic [IDX_W:0]    one_sh;
  logic [IDX_W-1:0]  bm1_new;

  always_comb begin
    sl_new  = size_log2(size_i);
    pl_new  = {1'b0, port_log2(port_i)};
    blog    = (sl_new > pl_new) ? (sl_new - pl_new) : 3'd0;
    one_sh  = (IDX_W+1)'(1) << blog;
    bm1_new = IDX_W'(one_sh - (IDX_W+1)'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      slog_q <= '0;
      plog_q <= '0;
      bm1_q  <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      base_q <= addr_i;
      slog_q <= sl_new;
      plog_q <= pl_new[1:0];
      bm1_q  <= bm1_new;
      idx_q  <= '0;
    end else if (adv_i) begin
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] step;
  assign mask    = (ADDR_W'(1) << slog_q) - ADDR_W'(1);
  assign step    = ADDR_W'(idx_q) << plog_q;
  // wrap within the size-aligned block
  assign addr_o  = (base_q & ~mask) | ((base_q + step) & mask);
  assign idx_o   = idx_q;
  assign plog_o  = plog_q;
  assign last_o  = (idx_q == bm1_q);
  assign burst_o = (bm1_q != '0);

  a_r9_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (idx_q <= bm1_q));

  a_r11_wrap_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !last_o) |=> (((addr_o - $past(addr_o)) & mask) == ((ADDR_W'(1) << plog_q) & mask)));
endmodule

// File: rtl/ebus_wait_timer.sv
module ebus_wait_timer #(
  parameter int WAIT_W     = 4,
  parameter int TMO_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] ws_i,
  input  logic              active_i,
  input  logic              auto_i,
  input  logic              ext_ack_i,
  output logic              ack_o,
  output logic              tmo_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= ws_i;
    else if (active_i && cnt_q != '0)  cnt_q <= cnt_q - WAIT_W'(1);
  end

  // external acknowledge may end the beat before the countdown
  assign ack_o = active_i && (ext_ack_i || (auto_i && cnt_q == '0));

  generate
    if (TMO_CYCLES > 0) begin : g_tmo
      localparam int TMO_W = $clog2(TMO_CYCLES + 1);
      localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);
      logic [TMO_W-1:0] tcnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             tcnt_q <= '0;
        else if (load_i)                         tcnt_q <= '0;
        else if (active_i && tcnt_q != TMO_LAST) tcnt_q <= tcnt_q + TMO_W'(1);
      end

      assign tmo_o = active_i && !auto_i && !ack_o && (tcnt_q == TMO_LAST);

      a_r12_tmo_ends_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_o |=> !active_i);
    end else begin : g_no_tmo
      assign tmo_o = 1'b0;
    end
  endgenerate

  a_r13_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(ws_i)));
endmodule

// File: rtl/ebus_data_path.sv
module ebus_data_path #(
  parameter int LINE_BYTES = 16,
  parameter int BUS_BYTES  = 4,
  parameter int IDX_W      = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [LINE_BYTES*8-1:0] wdata_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [1:0]              plog_i,
  input  logic                    cap_i,
  input  logic [BUS_BYTES*8-1:0]  rdata_i,
  output logic [BUS_BYTES*8-1:0]  wdata_o,
  output logic [LINE_BYTES*8-1:0] rdata_o
);
  localparam int LANE_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;
  localparam int OFF_W  = IDX_W + 2;

  logic [LINE_BYTES*8-1:0] wbuf_q;
  logic [OFF_W-1:0]        boff;
  logic [LINE_BYTES*8-1:0] wshift;
  logic [LANE_W-1:0]       lmask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wbuf_q <= '0;
    else if (start_i) wbuf_q <= wdata_i;
  end

  assign boff   = OFF_W'(idx_i) << plog_i;
  assign wshift = wbuf_q >> {boff, 3'b000};
  assign lmask  = LANE_W'((3'd1 << plog_i) - 3'd1);

  for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
    assign wdata_o[l*8 +: 8] = (3'(l) < (3'd1 << plog_i)) ? wshift[l*8 +: 8] : 8'h00;
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_rbyte
    logic [7:0]        byte_q;
    logic [IDX_W-1:0]  bb;
    logic [LANE_W-1:0] ln;
    assign bb = IDX_W'(b) >> plog_i;
    assign ln = LANE_W'(b) & lmask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       byte_q <= '0;
      else if (start_i)                  byte_q <= '0;
      else if (cap_i && bb == idx_i)     byte_q <= rdata_i[ln*8 +: 8];
    end
    assign rdata_o[b*8 +: 8] = byte_q;
  end

  a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && idx_i == '0) |=> (rdata_o[7:0] == $past(rdata_i[7:0])));
endmodule

// File: rtl/ebus_ack_ctrl.sv
module ebus_ack_ctrl
  import ebus_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int BUS_BYTES  = 4,
  parameter int WAIT_W     = 4,
  parameter int TMO_CYCLES = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_we_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [1:0]              req_size_i,
  input  logic [LINE_BYTES*8-1:0] req_wdata_i,
  input  logic [1:0]              cfg_port_i,
  input  logic                    cfg_auto_ack_i,
  input  logic [WAIT_W-1:0]       cfg_wait_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_err_o,
  output logic [LINE_BYTES*8-1:0] rsp_rdata_o,
  output logic                    cs_n_o,
  output logic                    burst_n_o,
  output logic [1:0]              tsize_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic                    we_o,
  output logic [BUS_BYTES*8-1:0]  wdata_o,
  output logic                    wdata_oe_o,
  input  logic [BUS_BYTES*8-1:0]  rdata_i,
  input  logic                    ta_ni
);
  localparam int IDX_W = $clog2(LINE_BYTES);

  ebus_state_e       state_q;
  logic              we_q;
  logic [1:0]        size_q;
  logic              auto_q;
  logic [WAIT_W-1:0] ws_q;
  logic              err_q;

  logic              accept, active, ext_ack, ack, tmo, last, burst, adv, load;
  logic [WAIT_W-1:0] ws_load;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        plog;

  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign active  = (state_q == ST_BEAT);
  assign ext_ack = active && !ta_ni;   // ignored while chip select is off
  assign adv     = ack && !last;
  assign load    = accept || adv;
  assign ws_load = accept ? cfg_wait_i : ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      size_q  <= '0;
      auto_q  <= 1'b0;
      ws_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_BEAT;
          we_q    <= req_we_i;
          size_q  <= req_size_i;
          auto_q  <= cfg_auto_ack_i;
          ws_q    <= cfg_wait_i;
          err_q   <= 1'b0;
        end
        ST_BEAT: begin
          if (ack && last) begin
            state_q <= ST_TAIL;
          end else if (tmo) begin
            state_q <= ST_TAIL;
            err_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ebus_beat_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .adv_i    (adv),
    .active_i (active),
    .addr_i   (req_addr_i),
    .size_i   (req_size_i),
    .port_i   (cfg_port_i),
    .idx_o    (idx),
    .plog_o   (plog),
    .last_o   (last),
    .burst_o  (burst),
    .addr_o   (addr_o)
  );

  ebus_wait_timer #(.WAIT_W(WAIT_W), .TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .ws_i      (ws_load),
    .active_i  (active),
    .auto_i    (auto_q),
    .ext_ack_i (ext_ack),
    .ack_o     (ack),
    .tmo_o     (tmo)
  );

  ebus_data_path #(.LINE_BYTES(LINE_BYTES), .BUS_BYTES(BUS_BYTES), .IDX_W(IDX_W)) u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .wdata_i (req_wdata_i),
    .idx_i   (idx),
    .plog_i  (plog),
    .cap_i   (ack && !we_q),
    .rdata_i (rdata_i),
    .wdata_o (wdata_o),
    .rdata_o (rsp_rdata_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign cs_n_o      = !active;
  assign burst_n_o   = !(active && burst);
  assign tsize_o     = size_q;
  assign we_o        = we_q && (state_q != ST_IDLE);
  // write data outlives chip select by the tail cycle
  assign wdata_oe_o  = we_q && (state_q != ST_IDLE);
  assign rsp_valid_o = (state_q == ST_TAIL);
  assign rsp_err_o   = err_q;

  a_r7_cs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ack && last) |=> (cs_n_o && rsp_valid_o));

  a_r7_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r8_wdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && we_o) |-> (cs_n_o && wdata_oe_o));

  a_r8_wdata_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!wdata_oe_o && req_ready_o));

  a_r9_burst_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_n_o |-> !cs_n_o);

  a_r2_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> !req_ready_o);

  a_r5_idle_ta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i && !ta_ni) |=> (cs_n_o && !rsp_valid_o));
endmodule

// File: tb/ebus_ack_ctrl_tb_top.sv
module ebus_ack_ctrl_tb_top;
  localparam int ADDR_W = 32;
  localparam int LB     = 16;
  localparam int BB     = 4;
  localparam int WAIT_W = 4;
  localparam int TMO    = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_we = 1'b0;
  logic [31:0]     req_addr = '0;
  logic [1:0]      req_size = '0;
  logic [LB*8-1:0] req_wdata = '0;
  logic [1:0]      cfg_port = '0;
  logic            cfg_auto = 1'b0;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic            rsp_valid, rsp_err;
  logic [LB*8-1:0] rsp_rdata;
  logic            cs_n, burst_n, we, wdata_oe;
  logic [1:0]      tsize;
  logic [31:0]     addr;
  logic [BB*8-1:0] wdata, rdata;
  logic            ta_n = 1'b1;

  always #2 clk = ~clk;

  function automatic logic [7:0] periph(logic [31:0] a, int lane);
    return a[7:0] ^ 8'(lane * 17) ^ 8'hC3;
  endfunction

  assign rdata = {periph(addr, 3), periph(addr, 2), periph(addr, 1), periph(addr, 0)};

  ebus_ack_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .BUS_BYTES(BB),
                  .WAIT_W(WAIT_W), .TMO_CYCLES(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .cfg_port_i(cfg_port), .cfg_auto_ack_i(cfg_auto), .cfg_wait_i(cfg_wait),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .cs_n_o(cs_n), .burst_n_o(burst_n), .tsize_o(tsize), .addr_o(addr),
    .we_o(we), .wdata_o(wdata), .wdata_oe_o(wdata_oe),
    .rdata_i(rdata), .ta_ni(ta_n)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  typedef struct {
    logic [31:0] addr;
    int          len;
    logic [31:0] wd;
    bit          we;
    bit          burst;
    logic [1:0]  size;
    string       tag;
  } beat_t;

  typedef struct {
    logic [127:0] rd;
    bit           err;
    bit           we;
  } rsp_t;

  beat_t beat_q[$];
  rsp_t  rsp_q[$];
  int    ext_delay = -1;
  bit    idle_ta   = 0;

  // driver: pushes expected beats and response, then issues the request
  task automatic xfer(bit w, logic [31:0] a, logic [1:0] sz, logic [1:0] pw,
                      bit au, int ws, int ext, logic [127:0] wd, string tag);
    int sb, pb, nb, len;
    bit tmo;
    rsp_t r;
    case (sz)
      2'b01: sb = 1;
      2'b10: sb = 2;
      2'b11: sb = 16;
      default: sb = 4;
    endcase
    case (pw)
      2'b01: pb = 1;
      2'b10: pb = 2;
      default: pb = 4;
    endcase
    nb = (sb > pb) ? sb / pb : 1;
    tmo = !au && ext < 0;
    if (au) len = (ext >= 0 && ext < ws) ? ext + 1 : ws + 1;
    else    len = (ext >= 0) ? ext + 1 : TMO;
    if (tmo) nb = 1;
    r.rd = '0; r.err = tmo; r.we = w;
    for (int k = 0; k < nb; k++) begin
      beat_t b;
      logic [31:0] m;
      m = 32'(sb - 1);
      b.addr  = (a & ~m) | ((a + 32'(k * pb)) & m);
      b.len   = len;
      b.we    = w;
      b.burst = ((sb > pb) ? sb / pb : 1) > 1;
      b.size  = sz;
      b.tag   = tag;
      b.wd    = '0;
      for (int j = 0; j < pb; j++) begin
        b.wd[j*8 +: 8] = wd[(k*pb + j)*8 +: 8];
        r.rd[(k*pb + j)*8 +: 8] = periph(b.addr, j);
      end
      beat_q.push_back(b);
    end
    rsp_q.push_back(r);
    while (!req_ready) @(negedge clk);
    req_we = w; req_addr = a; req_size = sz; req_wdata = wd;
    cfg_port = pw; cfg_auto = au; cfg_wait = WAIT_W'(ws); ext_delay = ext;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !cs_n, "R2 busy after accept", {req_ready, cs_n}, 2'b00);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor and peripheral model
  initial begin
    bit          open = 0;
    bit          post_tail = 0;
    int          len = 0;
    logic [31:0] paddr = '0;
    beat_t       cur;
    rsp_t        r;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (post_tail) begin
        chk(!wdata_oe && req_ready, "R8 data released after tail", {wdata_oe, req_ready}, 2'b01);
        post_tail = 0;
      end
      if (!cs_n) begin
        if (open && addr == paddr) len++;
        else begin
          if (open) chk(len == cur.len, {cur.tag, " beat length"}, 128'(len), 128'(cur.len));
          if (beat_q.size() == 0) begin
            chk(0, "R11 unexpected beat", addr, 0);
            cur.len = 0; cur.tag = "R11";
          end else begin
            cur = beat_q.pop_front();
            chk(addr == cur.addr, "R11 beat address", addr, cur.addr);
            chk(tsize == cur.size, "R10 size code", tsize, cur.size);
            chk(burst_n == !cur.burst, "R9 burst flag", burst_n, !cur.burst);
            if (cur.we) chk(wdata == cur.wd, "R9 write lanes", wdata, cur.wd);
          end
          open = 1; len = 1; paddr = addr;
        end
        ta_n = !(ext_delay >= 0 && (len - 1) == ext_delay);
      end else begin
        if (open) begin
          chk(len == cur.len, {cur.tag, " beat length"}, 128'(len), 128'(cur.len));
          open = 0;
          chk(rsp_valid, "R7 response with cs release", rsp_valid, 1);
          if (rsp_q.size() == 0) chk(0, "R7 unexpected response", 0, 1);
          else begin
            r = rsp_q.pop_front();
            chk(rsp_err == r.err, "R12 error flag", rsp_err, r.err);
            if (!r.we && !r.err) chk(rsp_rdata == r.rd, "R6 read data", rsp_rdata, r.rd);
            chk(wdata_oe == r.we, "R8 data held in tail", wdata_oe, r.we);
          end
          post_tail = 1;
        end
        ta_n = !idle_ta;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && burst_n && req_ready && !rsp_valid && !wdata_oe, "R1 reset state",
        {cs_n, burst_n, req_ready, rsp_valid, wdata_oe}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && burst_n && req_ready && !rsp_valid && !wdata_oe, "R1 after reset",
        {cs_n, burst_n, req_ready, rsp_valid, wdata_oe}, 5'b11100);

    xfer(0, 32'h0000_1000, 2'b00, 2'b00, 1, 2, -1, '0, "R3");
    xfer(1, 32'h0000_1008, 2'b00, 2'b00, 1, 0, -1, 128'hDEAD_BEEF, "R3");
    xfer(0, 32'h0000_1034, 2'b11, 2'b00, 1, 1, -1, '0, "R13");
    xfer(1, 32'h0000_202A, 2'b11, 2'b10, 1, 0, -1,
         128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, "R13");
    xfer(0, 32'h0000_0102, 2'b00, 2'b01, 1, 5, 0, '0, "R4");
    xfer(0, 32'h0000_3009, 2'b11, 2'b01, 0, 0, 2, '0, "R4");
    xfer(1, 32'h0000_4003, 2'b01, 2'b00, 0, 0, 0, 128'h5A, "R4");
    xfer(0, 32'h0000_5006, 2'b10, 2'b10, 1, 3, -1, '0, "R3");
    xfer(1, 32'h0000_6001, 2'b10, 2'b01, 1, 3, 1, 128'hA55A, "R4");
    xfer(0, 32'h0000_7000, 2'b00, 2'b00, 0, 0, -1, '0, "R12");

    idle_ta = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cs_n && !rsp_valid, "R5 idle acknowledge ignored", {cs_n, rsp_valid}, 2'b10);
    end
    xfer(0, 32'h0000_8010, 2'b00, 2'b00, 1, 3, -1, '0, "R5");
    idle_ta = 0;

    repeat (4) @(negedge clk);
    chk(beat_q.size() == 0 && rsp_q.size() == 0, "R2 all expected items seen",
        beat_q.size() + rsp_q.size(), 0);
    finish_run();
  end
endmodule